// File: doc/BRIEF.md
# Programmable Interval Counter Channel

One channel of a programmable interval timer. A 16-bit reload value and a 3-bit mode code are written together with a load strobe. The channel then counts single-cycle enable ticks and produces an output waveform and a readable count, following one of six operating laws: interrupt on terminal count, gate-retriggered one-shot, rate generator, square wave, software strobe and hardware strobe. A rising edge on the gate input restarts the current period in the modes that are retriggerable.

The channel holds no bus logic. Control-word decoding, count latching and byte sequencing belong to a neighbouring block, which drives the load strobe, the reload value and the mode code directly. All counting is binary. Every output law is a function of one elapsed-tick register and a few sticky flags, so the count and the output always describe the same instant.

Top module: `ictr_channel`

## Requirements
- R1: After synchronous reset the channel runs in mode 3 with a reload of 65536. The count reads 0 and the output is high. The first tick after reset brings the count to 65534.
- R2: A reload value of 0 acts as 65536. Right after such a load in mode 0 the count reads 0, and one tick later it reads 65535.
- R3: In mode 0 the output is low while fewer than N ticks have elapsed since the load, where N is the reload value. From the N-th tick on it is high, and it stays high until the next load.
- R4: In mode 1, after a load, the channel is idle until the first gate rising edge. While idle the output is low and the count shows N. From that edge on, the output is high for N ticks and then low.
- R5: In mode 2 the output is high for exactly the tick slots in which the elapsed tick count is a nonzero multiple of N. There is no pulse at the load itself. The count shows N minus (elapsed mod N).
- R6: In mode 3 the output is high while (elapsed mod N) < (N+1)/2 and low otherwise, so an odd N gives the extra tick to the high half. The count shows N minus ((2 x elapsed) mod N), so it falls by two per tick and wraps back to N.
- R7: In modes 4 and 5 the output is high only while exactly N ticks have elapsed, which gives one strobe per start. Mode 5 is idle, with the output low, until the first gate rising edge after a load.
- R8: In modes 0, 1, 4 and 5 the count shows (N minus elapsed) mod 65536, so it wraps to 65535 after reaching 0.
- R9: A gate rising edge restarts the elapsed count from zero in modes 1, 2, 3 and 5. In modes 0 and 4 it has no effect on the count or the output.
- R10: A load clears the elapsed count, and the count shows the loaded value in the next cycle. A load in the same cycle as a tick or a gate rising edge wins: neither the tick nor the edge takes effect.
- R11: Mode codes 6 and 7 behave as codes 2 and 3.
- R12: In a cycle with no tick, no load and no effective gate edge, the count and the output do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable, one cycle per counting step |
| load | input | 1 | Load strobe for reload value and mode |
| load_val | input | 16 | Reload value (0 means 65536) |
| load_mode | input | 3 | Operating mode code |
| gate | input | 1 | Gate level; rising edges retrigger |
| out_wave | output | 1 | Mode-dependent output waveform |
| count_now | output | 16 | Current readable count |

## Verification
Two kinds of collision can occur in a single cycle. A load can arrive with a tick, and a gate rising edge can arrive with a tick, or with a load in a retriggerable mode. The bench drives these on purpose: it raises the load strobe in the same cycle as a tick, and it raises the gate in the same cycle as a load in mode 5. Its tick-domain model expects the load to win. The count must show the fresh reload value with no tick taken off, and mode 5 must stay idle until a later gate edge.

// File: rtl/ictr_pkg.sv
// Shared types for the interval counter channel.
// Assumes mode codes 6 and 7 are aliases of the rate and square modes.
package ictr_pkg;

    typedef enum logic [2:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5
    } mode_e;

    // Map a raw 3-bit code onto one of the six modes.
    function automatic mode_e fold_mode(input logic [2:0] code);
        if (code[2:1] == 2'b11) begin
            return mode_e'({1'b0, code[1:0]});
        end
        return mode_e'(code);
    endfunction

    // True for modes in which a gate rising edge restarts the period.
    function automatic logic gate_restarts(input mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
    endfunction

    // True for modes that stay idle after a load until a gate edge.
    function automatic logic waits_for_gate(input mode_e m);
        return (m == M_ONESHOT) || (m == M_HWSTB);
    endfunction

    // True for modes whose elapsed count wraps every reload period.
    function automatic logic is_periodic(input mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/ictr_gate_edge.sv
// Gate rising-edge detector.
// Assumes the gate is already synchronous to clk.
module ictr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    // Remember the previous gate level.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/ictr_elapse.sv
// Elapsed-tick state of the channel: reload value, mode, elapsed count and
// the sticky flags the output law needs. Load has priority over a gate
// restart, and a gate restart has priority over a tick.
// Assumes CW >= 2; the reload register is CW+1 bits so it can hold 2**CW.
module ictr_elapse
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [2:0]    load_mode,
    input  logic          rise,
    output mode_e         mode_q,
    output logic [CW:0]   reload_q,
    output logic [CW:0]   elapsed_q,
    output logic          hit_q,
    output logic          over_q,
    output logic          ran_q,
    output logic          armed_q
);
    localparam int NW = CW + 1;
    localparam logic [NW-1:0] FULL = {1'b1, {CW{1'b0}}};

    mode_e         new_mode;
    logic [NW-1:0] new_reload;
    logic [NW-1:0] inc;
    logic [NW-1:0] elapsed_nxt;

    // Decode the incoming load and the next elapsed value.
    always_comb begin
        new_mode    = fold_mode(load_mode);
        new_reload  = (load_val == '0) ? FULL : {1'b0, load_val};
        inc         = elapsed_q + 1'b1;
        elapsed_nxt = (is_periodic(mode_q) && inc == reload_q) ? '0 : inc;
    end

    // Update mode, reload, elapsed count and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_SQUARE;
            reload_q  <= FULL;
            elapsed_q <= '0;
            hit_q     <= 1'b0;
            over_q    <= 1'b0;
            ran_q     <= 1'b0;
            armed_q   <= 1'b1;
        end else if (load) begin
            mode_q    <= new_mode;
            reload_q  <= new_reload;
            elapsed_q <= '0;
            hit_q     <= 1'b0;
            over_q    <= 1'b0;
            ran_q     <= 1'b0;
            armed_q   <= !waits_for_gate(new_mode);
        end else if (rise && gate_restarts(mode_q)) begin
            elapsed_q <= '0;
            hit_q     <= 1'b0;
            over_q    <= 1'b0;
            ran_q     <= 1'b0;
            armed_q   <= 1'b1;
        end else if (tick && armed_q) begin
            elapsed_q <= elapsed_nxt;
            ran_q     <= 1'b1;
            hit_q     <= hit_q | (inc == reload_q);
            over_q    <= over_q | hit_q;
        end
    end
endmodule

// File: rtl/ictr_out_law.sv
// Output and count laws of the six modes, evaluated from the elapsed state.
// Assumes elapsed < reload in the periodic modes.
module ictr_out_law
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  mode_e         mode,
    input  logic [CW:0]   reload,
    input  logic [CW:0]   elapsed,
    input  logic          hit,
    input  logic          over,
    input  logic          ran,
    input  logic          armed,
    output logic          out_o,
    output logic [CW-1:0] count_o
);
    localparam int NW = CW + 1;

    logic [NW:0] dbl;
    logic [NW:0] dbl_w;
    logic [NW:0] half;

    // Pick the output level and count for the current mode.
    always_comb begin
        dbl     = {elapsed, 1'b0};
        dbl_w   = (dbl >= {1'b0, reload}) ? dbl - {1'b0, reload} : dbl;
        half    = ({1'b0, reload} + 1'b1) >> 1;
        count_o = CW'(reload - elapsed);
        out_o   = 1'b0;
        case (mode)
            M_TERM:    out_o = hit;
            M_ONESHOT: out_o = armed && !hit;
            M_RATE:    out_o = ran && (elapsed == '0);
            M_SQUARE: begin
                out_o   = {1'b0, elapsed} < half;
                count_o = CW'({1'b0, reload} - dbl_w);
            end
            M_SWSTB,
            M_HWSTB:   out_o = armed && hit && !over;
            default:   out_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ictr_channel.sv
// Top of one interval counter channel: gate edge detector, elapsed state
// and output law. Assumes tick, load and gate are synchronous to clk.
module ictr_channel
    import ictr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic [2:0]    load_mode,
    input  logic          gate,
    output logic          out_wave,
    output logic [CW-1:0] count_now
);
    logic        gate_rise;
    mode_e       mode_q;
    logic [CW:0] reload_q;
    logic [CW:0] elapsed_q;
    logic        hit_q, over_q, ran_q, armed_q;

    ictr_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (gate_rise)
    );

    ictr_elapse #(.CW(CW)) u_elapse (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .load_val  (load_val),
        .load_mode (load_mode),
        .rise      (gate_rise),
        .mode_q    (mode_q),
        .reload_q  (reload_q),
        .elapsed_q (elapsed_q),
        .hit_q     (hit_q),
        .over_q    (over_q),
        .ran_q     (ran_q),
        .armed_q   (armed_q)
    );

    ictr_out_law #(.CW(CW)) u_law (
        .mode    (mode_q),
        .reload  (reload_q),
        .elapsed (elapsed_q),
        .hit     (hit_q),
        .over    (over_q),
        .ran     (ran_q),
        .armed   (armed_q),
        .out_o   (out_wave),
        .count_o (count_now)
    );
endmodule

// File: rtl/ictr_channel_chk.sv
// Property checker for the interval counter channel, bound to the top.
module ictr_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          load,
    input logic [CW-1:0] load_val,
    input logic          rise,
    input logic [2:0]    mode_q,
    input logic          out_wave,
    input logic [CW-1:0] count_now
);
    // R12: with nothing happening the outputs hold.
    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load && !rise) |=> ($stable(count_now) && $stable(out_wave)));

    // R10: the cycle after a load shows the loaded value.
    a_r10_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_now == $past(load_val)));

    // R3: mode 0 output stays high until the next load.
    a_r3_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && out_wave && !load) |=> out_wave);

    // R7: the strobe in modes 4 and 5 lasts a single tick.
    a_r7_strobe_once: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == 3'd4 || mode_q == 3'd5) && out_wave && tick && !load && !rise)
        |=> !out_wave);

    // R5: the rate pulse lasts one tick when the period exceeds one.
    a_r5_rate_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && out_wave && tick && !load && !rise && count_now != 1)
        |=> !out_wave);
endmodule

bind ictr_channel ictr_channel_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_val  (load_val),
    .rise      (gate_rise),
    .mode_q    (mode_q),
    .out_wave  (out_wave),
    .count_now (count_now)
);

// File: tb/tb_ictr_channel.sv
module tb_ictr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [15:0] load_val = '0;
    logic [2:0]  load_mode = '0;
    logic        gate = 1'b0;
    logic        out_wave;
    logic [15:0] count_now;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ictr_channel dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(load_val), .load_mode(load_mode), .gate(gate),
        .out_wave(out_wave), .count_now(count_now)
    );

    typedef struct {
        logic        o;
        logic [15:0] c;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    // Tick-domain reference model.
    int mN = 65536, md = 0, mm = 3;
    bit marmed = 1, mgprev = 0;

    function automatic int wrap16(input int v);
        return ((v % 65536) + 65536) % 65536;
    endfunction

    function automatic exp_t predict(input string tag);
        exp_t e;
        e.tag = tag;
        if (!marmed) begin
            e.o = 1'b0;
            e.c = 16'(wrap16(mN));
        end else begin
            case (mm)
                0: begin e.o = (md >= mN);  e.c = 16'(wrap16(mN - md)); end
                1: begin e.o = (md < mN);   e.c = 16'(wrap16(mN - md)); end
                2: begin e.o = ((md % mN) == 0) && (md != 0);
                         e.c = 16'(wrap16(mN - (md % mN))); end
                3: begin e.o = (md % mN) < ((mN + 1) / 2);
                         e.c = 16'(wrap16(mN - ((2 * md) % mN))); end
                default: begin e.o = (md == mN); e.c = 16'(wrap16(mN - md)); end
            endcase
        end
        return e;
    endfunction

    // Driver: apply one cycle of stimulus, advance the model, push expectation.
    task automatic step(input bit t, input bit l, input int v, input int m,
                        input bit g, input string tag);
        bit r;
        @(negedge clk);
        tick = t; load = l; load_val = 16'(v); load_mode = 3'(m); gate = g;
        @(posedge clk);
        #1;
        r = g && !mgprev;
        if (l) begin
            mm = (m >= 6) ? m - 4 : m;
            mN = (v == 0) ? 65536 : v;
            md = 0;
            marmed = !(mm == 1 || mm == 5);
        end else if (r && (mm == 1 || mm == 2 || mm == 3 || mm == 5)) begin
            md = 0;
            marmed = 1;
        end else if (t && marmed) begin
            md++;
        end
        mgprev = g;
        sbq.push_back(predict(tag));
    endtask

    task automatic ticks(input int n, input bit g, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, g, tag);
    endtask

    // Monitor: pop expectations and compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_cmp++;
            if (out_wave !== e.o || count_now !== e.c) begin
                n_bad++;
                $display("FAIL %s: out=%0b count=%0d expected out=%0b count=%0d",
                         e.tag, out_wave, count_now, e.o, e.c);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R1 reset state");
        step(1, 0, 0, 0, 0, "R1 first tick");
        // R10: load collides with a tick; load wins
        step(1, 1, 5, 0, 0, "R10 load with tick");
        ticks(4, 0, "R3 mode0 counting");
        ticks(1, 0, "R3 mode0 terminal");
        ticks(2, 0, "R8 mode0 wrap");
        step(0, 0, 0, 0, 1, "R9 mode0 gate ignored");
        step(0, 0, 0, 0, 0, "R12 hold");
        step(0, 1, 0, 0, 0, "R2 zero load");
        ticks(1, 0, "R2 zero load tick");
        // mode 1
        step(0, 1, 3, 1, 0, "R4 mode1 load idle");
        ticks(2, 0, "R4 mode1 idle ticks");
        step(0, 0, 0, 0, 1, "R4 mode1 trigger");
        ticks(4, 1, "R4 mode1 run");
        step(0, 0, 0, 0, 0, "R12 hold");
        step(0, 0, 0, 0, 1, "R9 mode1 retrigger");
        ticks(1, 1, "R8 mode1 count");
        // mode 2
        step(0, 1, 4, 2, 0, "R5 mode2 load");
        ticks(9, 0, "R5 mode2 pulses");
        step(1, 0, 0, 0, 1, "R9 mode2 restart");
        ticks(5, 1, "R5 mode2 after restart");
        // mode 3 odd and even
        step(0, 1, 5, 3, 0, "R6 mode3 odd load");
        ticks(11, 0, "R6 mode3 odd");
        step(0, 1, 4, 3, 0, "R6 mode3 even load");
        ticks(9, 0, "R6 mode3 even");
        step(1, 0, 0, 0, 1, "R9 mode3 restart");
        ticks(3, 1, "R6 mode3 after restart");
        // mode 4
        step(0, 1, 3, 4, 0, "R7 mode4 load");
        ticks(2, 0, "R7 mode4 count");
        step(0, 0, 0, 0, 1, "R9 mode4 gate ignored");
        ticks(4, 1, "R7 mode4 strobe");
        // mode 5, load colliding with gate edge
        step(0, 0, 0, 0, 0, "R12 hold");
        step(0, 1, 2, 5, 1, "R10 load with gate edge");
        ticks(2, 1, "R7 mode5 idle");
        step(0, 0, 0, 0, 0, "R12 hold");
        step(0, 0, 0, 0, 1, "R7 mode5 trigger");
        ticks(4, 1, "R7 mode5 strobe");
        // aliases
        step(0, 1, 3, 6, 0, "R11 code6 load");
        ticks(7, 0, "R11 code6 as rate");
        step(0, 1, 5, 7, 0, "R11 code7 load");
        ticks(6, 0, "R11 code7 as square");
        step(0, 0, 0, 0, 0, "R12 hold");
        step(0, 0, 0, 0, 0, "R12 hold");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: out=%0b count=%0d expected completion", out_wave, count_now);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule